// File: doc/BRIEF.md
# Single-Trigger GPIO Controller

This block is a memory-mapped general-purpose I/O controller for 22 pins. A processor reaches it over a plain 32-bit register bus: an address, a write strobe, write data, and combinational read data. Software owns an output-value register and a direction register. The direction bits appear on the pads as output-enable signals. The pad inputs pass through a two-flop synchroniser and can then be read back as a read-only input word.

Interrupts are not handled per pin. One configuration word names a single watched pin and a trigger mode. The mode is off, low level, high level or any-change. Only that pin can raise the single interrupt line. In the any-change mode a sticky flag holds the event, and any write to the configuration word clears that flag. Software typically toggles one output bit by reading the output word, changing the bit, and writing the word back, so every register reads back exactly what was stored.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe_o = 0), the output word is 0, the configuration word is 0 (mode off, index 0), and irq_o is low.
- R2: A write to offset 0x08 stores bits [21:0] as the output word. A read of 0x08 returns exactly that value, with bits [31:22] read as 0. pin_o shows the word from the cycle after the write.
- R3: A write to offset 0x10 stores the direction word. Bit n = 1 makes pin n an output (pin_oe_o[n] = 1), and bit n = 0 makes it an input. A read of 0x10 returns the stored value, with the upper bits read as 0.
- R4: The output word keeps its value whatever the direction word holds. Changing direction never alters pin_o or the value read back at 0x08.
- R5: A read of offset 0x00 returns pin_i after two clock edges of synchronisation, with upper bits 0. Writes to 0x00 have no effect.
- R6: Offset 0x18 holds the configuration word: bits [5:0] are the watched pin index and bits [7:6] are the mode. A read returns both fields, with bits [31:8] read as 0.
- R7: With mode 0 (off), irq_o stays low whatever the pins do.
- R8: With mode 1 (low level), irq_o is high exactly while the synchronised watched pin is 0.
- R9: With mode 2 (high level), irq_o is high exactly while the synchronised watched pin is 1.
- R10: With mode 3 (any change), a rise or a fall of the synchronised watched pin sets a sticky flag that drives irq_o. The flag stays set when the pin changes back, and changes on other pins have no effect.
- R11: Any write to 0x18 clears the sticky flag. If a change of the watched pin is detected on the same edge as the write, the write wins and the change is dropped.
- R12: A watched pin index of 22 or more never raises irq_o, in any mode.
- R13: Reads of unused offsets (for example 0x04 and 0x1C) return 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | 22 | Pad input values, asynchronous |
| pin_o | output | 22 | Pad output values |
| pin_oe_o | output | 22 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Two events can fall on the same clock edge: a write to the configuration word, and the detection of a change on the watched pin in any-change mode. The bench triggers this collision by counting edges from a pin change. It asserts the configuration write so that it lands on the same edge as the third synchroniser stage. The expected result is that irq_o stays low afterwards. The bench then repeats the sequence with the write placed one edge earlier, and in that case irq_o must rise.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned IDX_W = 6;

  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_LOW  = 2'd1,
    TRG_HIGH = 2'd2,
    TRG_EDGE = 2'd3
  } trig_mode_e;

  // packed so that mode lands in [7:6] and index in [5:0]
  typedef struct packed {
    trig_mode_e        mode;
    logic [IDX_W-1:0]  idx;
  } trig_cfg_t;

  localparam int unsigned CFG_W = $bits(trig_cfg_t);

  localparam logic [7:0] OFS_IN  = 8'h00;
  localparam logic [7:0] OFS_OUT = 8'h08;
  localparam logic [7:0] OFS_DIR = 8'h10;
  localparam logic [7:0] OFS_CFG = 8'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 22,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] sync_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output trig_cfg_t           cfg_o,
  output logic                cfg_wr_o
);
  logic sel_out, sel_dir, sel_cfg, sel_in;
  logic [NUM_PINS-1:0] out_q, dir_q;
  trig_cfg_t cfg_q;

  assign sel_in  = (addr_i == ADDR_W'(OFS_IN));
  assign sel_out = (addr_i == ADDR_W'(OFS_OUT));
  assign sel_dir = (addr_i == ADDR_W'(OFS_DIR));
  assign sel_cfg = (addr_i == ADDR_W'(OFS_CFG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      cfg_q <= '{mode: TRG_OFF, idx: '0};
    end else if (we_i) begin
      if (sel_out) out_q <= wdata_i[NUM_PINS-1:0];
      if (sel_dir) dir_q <= wdata_i[NUM_PINS-1:0];
      if (sel_cfg) cfg_q <= trig_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_in:  rdata_o = REG_W'(sync_i);
      sel_out: rdata_o = REG_W'(out_q);
      sel_dir: rdata_o = REG_W'(dir_q);
      sel_cfg: rdata_o = REG_W'(cfg_q);
      default: rdata_o = '0;
    endcase
  end

  assign out_o    = out_q;
  assign dir_o    = dir_q;
  assign cfg_o    = cfg_q;
  assign cfg_wr_o = we_i & sel_cfg;
endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  trig_cfg_t           cfg_i,
  input  logic                cfg_wr_i,
  output logic                irq_o
);
  localparam int unsigned PAD_W = 1 << IDX_W;

  logic [NUM_PINS-1:0] prev_q;
  logic [PAD_W-1:0]    cur_pad, prev_pad;
  logic                idx_ok, cur_bit, prev_bit, changed, pend_q;

  assign cur_pad  = PAD_W'(sync_i);
  assign prev_pad = PAD_W'(prev_q);
  assign idx_ok   = (cfg_i.idx < IDX_W'(NUM_PINS));
  assign cur_bit  = cur_pad[cfg_i.idx];
  assign prev_bit = prev_pad[cfg_i.idx];
  assign changed  = idx_ok & (cur_bit ^ prev_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      // config write wins over a coincident change
      if (cfg_wr_i)                                pend_q <= 1'b0;
      else if (cfg_i.mode == TRG_EDGE && changed)  pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (cfg_i.mode)
      TRG_LOW:  irq_o = idx_ok & ~cur_bit;
      TRG_HIGH: irq_o = idx_ok &  cur_bit;
      TRG_EDGE: irq_o = pend_q;
      default:  irq_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_trig_ctrl.sv
module gpio_trig_ctrl
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] sync_w;
  trig_cfg_t           cfg_q;
  logic                cfg_wr;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .sync_i  (sync_w),
    .out_o   (pin_o),
    .dir_o   (pin_oe_o),
    .cfg_o   (cfg_q),
    .cfg_wr_o(cfg_wr)
  );

  gpio_trig_unit #(.NUM_PINS(NUM_PINS)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_w),
    .cfg_i   (cfg_q),
    .cfg_wr_i(cfg_wr),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gpio_trig_chk.sv
module gpio_trig_chk #(
  parameter int unsigned NUM_PINS = 22,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [31:0]         wdata_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [5:0]          cfg_idx_i,
  input logic [1:0]          cfg_mode_i
);
  logic wr_out, wr_dir, wr_cfg;
  assign wr_out = we_i && addr_i == ADDR_W'(8'h08);
  assign wr_dir = we_i && addr_i == ADDR_W'(8'h10);
  assign wr_cfg = we_i && addr_i == ADDR_W'(8'h18);

  p_oe_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pin_oe_o == $past(wdata_i[NUM_PINS-1:0]));

  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_out |=> $stable(pin_o));

  p_off_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i == 2'd0 |-> !irq_o);

  p_edge_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == 2'd3 && irq_o && !wr_cfg) |=> irq_o);

  p_cfg_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && wdata_i[7:6] == 2'd3) |=> !irq_o);

  p_bad_idx_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_idx_i >= 6'(NUM_PINS) |-> !irq_o);
endmodule

bind gpio_trig_ctrl gpio_trig_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o),
  .cfg_idx_i (cfg_q.idx),
  .cfg_mode_i(cfg_q.mode)
);

// File: tb/gpio_trig_ctrl_bench.sv
module gpio_trig_ctrl_bench;
  localparam int NP = 22;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_o, pin_oe_o;
  logic          irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_trig_ctrl u_gpio_trig_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8'h08, 32'h003F_FFFF, 32'h003F_FFFF},  // R2
    '{8'h08, 32'hFFFF_FFFF, 32'h003F_FFFF},  // R2 upper dropped
    '{8'h08, 32'h0015_5555, 32'h0015_5555},  // R2
    '{8'h10, 32'hAAAA_AAAA, 32'h002A_AAAA},  // R3
    '{8'h10, 32'h0000_0000, 32'h0000_0000},  // R3
    '{8'h18, 32'h0000_00C5, 32'h0000_00C5},  // R6
    '{8'h18, 32'hFFFF_FFFF, 32'h0000_00FF},  // R6
    '{8'h18, 32'h0000_0000, 32'h0000_0000},  // R6
    '{8'h00, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 write ignored
    '{8'h04, 32'h1234_5678, 32'h0000_0000},  // R13
    '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0000}   // R13
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1 chk(rdata_o, exp, tag);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk_i);
    pin_i = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h08, 32'h0, "R1 out");
    rd(8'h10, 32'h0, "R1 dir");
    rd(8'h18, 32'h0, "R1 cfg");
    chk(32'(pin_oe_o), 32'h0, "R1 oe");
    chk(32'(irq_o), 32'h0, "R1 irq");

    // register vectors
    for (int i = 0; i < 11; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, VECS[i].e, "R2/R3/R5/R6/R13 readback");
      if (VECS[i].a == 8'h08) chk(32'(pin_o), VECS[i].e, "R2 pin_o");
      if (VECS[i].a == 8'h10) chk(32'(pin_oe_o), VECS[i].e, "R3 pin_oe_o");
    end
    chk(32'(pin_o), 32'h0015_5555, "R13 out untouched");
    chk(32'(pin_oe_o), 32'h0, "R13 dir untouched");

    // R4 output word kept across direction changes
    wr(8'h10, 32'h003F_FFFF);
    rd(8'h08, 32'h0015_5555, "R4 out after dir=1");
    wr(8'h10, 32'h0);
    chk(32'(pin_o), 32'h0015_5555, "R4 pin_o after dir=0");

    // R5 two-stage synchronisation latency
    @(negedge clk_i); addr_i = 8'h00;
    pin_i = 22'h2A_5A5A;
    settle(1); chk(rdata_o, 32'h0, "R5 one edge");
    settle(1); chk(rdata_o, 32'h002A_5A5A, "R5 two edges");
    set_pins('0); settle(3);

    // R7 off
    wr(8'h18, 32'h0000_0003);
    set_pins(22'h8); settle(3); chk(32'(irq_o), 32'h0, "R7 off pin high");
    set_pins('0);    settle(3); chk(32'(irq_o), 32'h0, "R7 off pin low");

    // R9 high level
    wr(8'h18, 32'h0000_0083);
    chk(32'(irq_o), 32'h0, "R9 low pin");
    set_pins(22'h8); settle(2); chk(32'(irq_o), 32'h1, "R9 high pin");
    set_pins(22'h3F_FFF7); settle(2); chk(32'(irq_o), 32'h0, "R9 others high");

    // R8 low level
    wr(8'h18, 32'h0000_0043);
    chk(32'(irq_o), 32'h1, "R8 pin low");
    set_pins(22'h8); settle(2); chk(32'(irq_o), 32'h0, "R8 pin high");

    // R12 out-of-range index
    set_pins('1); settle(3);
    wr(8'h18, 32'h0000_0096); settle(1); chk(32'(irq_o), 32'h0, "R12 high idx22");
    set_pins('0); settle(3);
    wr(8'h18, 32'h0000_007F); settle(1); chk(32'(irq_o), 32'h0, "R12 low idx63");
    wr(8'h18, 32'h0000_00FF);
    set_pins('1); settle(4); chk(32'(irq_o), 32'h0, "R12 edge idx63");
    set_pins('0); settle(4);

    // R10 any-change sticky
    wr(8'h18, 32'h0000_00C5);
    set_pins(22'h3F_FFDF); settle(4); chk(32'(irq_o), 32'h0, "R10 other pins");
    set_pins(22'h20);      settle(2); chk(32'(irq_o), 32'h0, "R10 before 3rd edge");
    settle(1);             chk(32'(irq_o), 32'h1, "R10 rise");
    set_pins(22'h0);       settle(4); chk(32'(irq_o), 32'h1, "R10 sticky");

    // R11 clear and fall detection
    wr(8'h18, 32'h0000_00C5); settle(1); chk(32'(irq_o), 32'h0, "R11 cleared");
    set_pins(22'h20); settle(4); chk(32'(irq_o), 32'h1, "R10 rise again");
    wr(8'h18, 32'h0000_00C5);
    set_pins(22'h0); settle(4); chk(32'(irq_o), 32'h1, "R10 fall");
    wr(8'h18, 32'h0000_00C5); settle(1);

    // R11 collision: write lands on the detection edge
    set_pins(22'h20);
    @(negedge clk_i); @(negedge clk_i);
    addr_i = 8'h18; wdata_i = 32'h0000_00C5; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    #1 chk(32'(irq_o), 32'h0, "R11 collision dropped");
    settle(3); chk(32'(irq_o), 32'h0, "R11 stays low");

    // R11 contrast: write one edge earlier
    set_pins(22'h0);
    @(negedge clk_i);
    addr_i = 8'h18; wdata_i = 32'h0000_00C5; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    @(negedge clk_i);
    #1 chk(32'(irq_o), 32'h1, "R11 earlier write keeps edge");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule